// File: doc/BRIEF.md
# E3 G.832 Frame Generator

This block produces a continuous octet stream of E3 frames in the G.832 layout. Each frame carries 537 octets laid out over nine rows. The first six rows are 60 columns wide and the last three are 59 columns wide. A position counter walks through every slot of the frame. Seven overhead octets sit in fixed slots:

- The two framing octets fill the first two columns of row 1.
- The five host-supplied overhead octets fill column 1 of rows 2 to 6, in the order error-monitor, trail-trace, maintenance/adaptation, network-operator, general-purpose channel.

Every other slot carries payload. Payload is pulled from an upstream source over a ready/valid handshake.

A downstream line stage drives a byte strobe, one pulse per octet it wants. For each strobe the generator emits one octet, registered, on the next cycle. The octet comes with its row and column, and with a start-of-frame mark on the first framing octet. The host loads the five overhead values into holding registers. These values are copied into the working set only at a frame boundary, so one frame never mixes old and new overhead. The generator runs only when the mode inputs select E3 (not DS3) together with the G.832 format.

Top module: `e3g832_framegen`

## Requirements
- R1: The generator is active only when `cfg_ds3_sel`=0 and `cfg_g832_sel`=1. Otherwise `tx_valid` and `pl_ready` stay low and the position returns to row 1, column 1, so the next active strobe emits the first framing octet.
- R2: While active, each cycle with `oct_en`=1 yields exactly one octet with `tx_valid`=1 on the following cycle. A cycle without a strobe yields `tx_valid`=0 and does not advance the position.
- R3: `tx_row` counts 1..9. `tx_col` counts 1..60 on rows 1-6 and 1..59 on rows 7-9. After row 9, column 59 the next octet is row 1, column 1, giving 537 octets per frame.
- R4: Row 1 column 1 carries 8'hF6 and row 1 column 2 carries 8'h28. `tx_sof` is high only with the octet at row 1, column 1.
- R5: Column 1 of rows 2, 3, 4, 5, 6 carries the overhead register written with `host_sel` 0, 1, 2, 3, 4 respectively. Writes with `host_sel` 5..7 change nothing.
- R6: A host write takes effect from the next frame start. Overhead octets still to come in the current frame keep the values that were latched when that frame began.
- R7: All other slots are payload. `pl_ready` is high exactly in cycles with a strobe on a payload slot. Payload octets are emitted in the order they were accepted.
- R8: A strobe on a payload slot with `pl_valid`=0 emits 8'h00, accepts no payload, and sets `tx_underrun`. `tx_underrun` then stays high until reset.
- R9: After reset `tx_valid`, `tx_sof` and `tx_underrun` are 0, all overhead registers are 0, and the position is row 1, column 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_ds3_sel | input | 1 | 1 selects DS3 (generator idle), 0 selects E3 |
| cfg_g832_sel | input | 1 | 1 selects the G.832 frame format |
| oct_en | input | 1 | Byte strobe: request one octet |
| pl_data | input | 8 | Payload octet from upstream |
| pl_valid | input | 1 | Upstream payload octet is available |
| pl_ready | output | 1 | Payload octet taken this cycle |
| host_wr | input | 1 | Overhead register write strobe |
| host_sel | input | 3 | Overhead register index (0..4 used) |
| host_wdata | input | 8 | Overhead register write value |
| tx_data | output | 8 | Emitted octet |
| tx_valid | output | 1 | `tx_data` holds a new octet |
| tx_sof | output | 1 | Octet is the first of a frame |
| tx_row | output | 4 | Row of the emitted octet (1..9) |
| tx_col | output | 6 | Column of the emitted octet (1..60) |
| tx_underrun | output | 1 | Sticky: a payload slot found no data |

## Verification
The bench targets the point where the row length changes from 60 to 59. A counter that used one length for all rows would produce 540 or 531 octets per frame and misplace the start-of-frame mark.

It writes the overhead registers in the middle of a frame. A design without a frame-boundary copy would emit the new trail-trace value in the same frame.

It starves the payload source and inserts strobe gaps. This exposes a design that advances on idle cycles, consumes payload during a starved slot, or clears the underrun flag by itself.

It drops the mode gate in the middle of a frame. A generator that resumed where it stopped, instead of at the framing octet, fails this test.

// File: rtl/e3fg_pkg.sv
package e3fg_pkg;

  localparam logic [7:0] FRAME_WORD_A = 8'hF6;
  localparam logic [7:0] FRAME_WORD_B = 8'h28;

  typedef enum logic [1:0] {
    SLOT_FRM_A = 2'd0,
    SLOT_FRM_B = 2'd1,
    SLOT_OVHD  = 2'd2,
    SLOT_PAYLD = 2'd3
  } slot_kind_e;

endpackage

// File: rtl/e3fg_pos.sv
module e3fg_pos #(
  parameter int ROWS      = 9,
  parameter int LONG_ROWS = 6,
  parameter int LONG_COLS = 60,
  parameter int ROW_W     = $clog2(ROWS + 1),
  parameter int COL_W     = $clog2(LONG_COLS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             adv,
  output logic [ROW_W-1:0] row,
  output logic [COL_W-1:0] col
);

  localparam logic [ROW_W-1:0] ROW_ONE  = ROW_W'(1);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS);
  localparam logic [ROW_W-1:0] ROW_LONG = ROW_W'(LONG_ROWS);
  localparam logic [COL_W-1:0] COL_ONE  = COL_W'(1);
  localparam logic [COL_W-1:0] COL_LONG = COL_W'(LONG_COLS);
  localparam logic [COL_W-1:0] COL_SHRT = COL_W'(LONG_COLS - 1);

  logic [COL_W-1:0] row_len;
  logic             at_row_end;

  always_comb begin
    row_len    = (row <= ROW_LONG) ? COL_LONG : COL_SHRT;
    at_row_end = (col == row_len);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      row <= ROW_ONE;
      col <= COL_ONE;
    end else if (adv) begin
      if (at_row_end) begin
        col <= COL_ONE;
        row <= (row == ROW_LAST) ? ROW_ONE : row + ROW_ONE;
      end else begin
        col <= col + COL_ONE;
      end
    end
  end

  // R3: position always inside the ragged frame shape
  a_r3_pos_legal: assert property (@(posedge clk) disable iff (rst)
    (row >= ROW_ONE) && (row <= ROW_LAST) && (col >= COL_ONE) && (col <= row_len));

  // R3: last slot of the frame wraps to the first
  a_r3_frame_wrap: assert property (@(posedge clk) disable iff (rst)
    (adv && !clr && row == ROW_LAST && col == COL_SHRT) |=> (row == ROW_ONE && col == COL_ONE));

  // R2: no strobe, no movement
  a_r2_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!adv && !clr) |=> ($stable(row) && $stable(col)));

endmodule

// File: rtl/e3fg_slotmap.sv
module e3fg_slotmap
  import e3fg_pkg::*;
#(
  parameter int NUM_OH = 5,
  parameter int ROW_W  = 4,
  parameter int COL_W  = 6,
  parameter int SEL_W  = $clog2(NUM_OH)
) (
  input  logic [ROW_W-1:0] row,
  input  logic [COL_W-1:0] col,
  output slot_kind_e       kind,
  output logic [SEL_W-1:0] oh_idx
);

  localparam logic [ROW_W-1:0] OH_FIRST = ROW_W'(2);
  localparam logic [ROW_W-1:0] OH_LAST  = ROW_W'(NUM_OH + 1);

  always_comb begin
    oh_idx = SEL_W'(row - OH_FIRST);
    if (row == ROW_W'(1) && col == COL_W'(1)) begin
      kind = SLOT_FRM_A;
    end else if (row == ROW_W'(1) && col == COL_W'(2)) begin
      kind = SLOT_FRM_B;
    end else if (row >= OH_FIRST && row <= OH_LAST && col == COL_W'(1)) begin
      kind = SLOT_OVHD;
    end else begin
      kind = SLOT_PAYLD;
    end
  end

endmodule

// File: rtl/e3fg_ohbank.sv
module e3fg_ohbank #(
  parameter int NUM_OH = 5,
  parameter int OCT_W  = 8,
  parameter int SEL_W  = $clog2(NUM_OH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [OCT_W-1:0] wr_data,
  input  logic             load,
  input  logic [SEL_W-1:0] rd_idx,
  output logic [OCT_W-1:0] rd_data
);

  logic [OCT_W-1:0] pend [NUM_OH];
  logic [OCT_W-1:0] live [NUM_OH];

  for (genvar g = 0; g < NUM_OH; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        pend[g] <= '0;
      end else if (wr && wr_sel == SEL_W'(g)) begin
        pend[g] <= wr_data;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        live[g] <= '0;
      end else if (load) begin
        live[g] <= pend[g];
      end
    end

    // R6: working copy moves only at a frame start
    a_r6_live_frozen: assert property (@(posedge clk) disable iff (rst)
      !load |=> $stable(live[g]));
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_OH; i++) begin
      if (rd_idx == SEL_W'(i)) rd_data = live[i];
    end
  end

endmodule

// File: rtl/e3g832_framegen.sv
module e3g832_framegen
  import e3fg_pkg::*;
#(
  parameter int OCT_W     = 8,
  parameter int ROWS      = 9,
  parameter int LONG_ROWS = 6,
  parameter int LONG_COLS = 60,
  parameter int NUM_OH    = 5,
  localparam int ROW_W    = $clog2(ROWS + 1),
  localparam int COL_W    = $clog2(LONG_COLS + 1),
  localparam int SEL_W    = $clog2(NUM_OH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_ds3_sel,
  input  logic             cfg_g832_sel,
  input  logic             oct_en,
  input  logic [OCT_W-1:0] pl_data,
  input  logic             pl_valid,
  output logic             pl_ready,
  input  logic             host_wr,
  input  logic [SEL_W-1:0] host_sel,
  input  logic [OCT_W-1:0] host_wdata,
  output logic [OCT_W-1:0] tx_data,
  output logic             tx_valid,
  output logic             tx_sof,
  output logic [ROW_W-1:0] tx_row,
  output logic [COL_W-1:0] tx_col,
  output logic             tx_underrun
);

  logic             active;
  logic             strobe;
  logic [ROW_W-1:0] cur_row;
  logic [COL_W-1:0] cur_col;
  slot_kind_e       kind;
  logic [SEL_W-1:0] oh_idx;
  logic [OCT_W-1:0] oh_val;
  logic             frame_start;
  logic             starved;
  logic [OCT_W-1:0] next_oct;

  assign active      = !cfg_ds3_sel && cfg_g832_sel;
  assign strobe      = active && oct_en;
  assign frame_start = strobe && (kind == SLOT_FRM_A);
  assign pl_ready    = strobe && (kind == SLOT_PAYLD);
  assign starved     = pl_ready && !pl_valid;

  e3fg_pos #(
    .ROWS(ROWS), .LONG_ROWS(LONG_ROWS), .LONG_COLS(LONG_COLS),
    .ROW_W(ROW_W), .COL_W(COL_W)
  ) pos_i (
    .clk(clk), .rst(rst), .clr(!active), .adv(strobe),
    .row(cur_row), .col(cur_col)
  );

  e3fg_slotmap #(
    .NUM_OH(NUM_OH), .ROW_W(ROW_W), .COL_W(COL_W), .SEL_W(SEL_W)
  ) map_i (
    .row(cur_row), .col(cur_col), .kind(kind), .oh_idx(oh_idx)
  );

  e3fg_ohbank #(
    .NUM_OH(NUM_OH), .OCT_W(OCT_W), .SEL_W(SEL_W)
  ) bank_i (
    .clk(clk), .rst(rst), .wr(host_wr), .wr_sel(host_sel), .wr_data(host_wdata),
    .load(frame_start), .rd_idx(oh_idx), .rd_data(oh_val)
  );

  always_comb begin
    unique case (kind)
      SLOT_FRM_A: next_oct = OCT_W'(FRAME_WORD_A);
      SLOT_FRM_B: next_oct = OCT_W'(FRAME_WORD_B);
      SLOT_OVHD:  next_oct = oh_val;
      default:    next_oct = pl_valid ? pl_data : '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid    <= 1'b0;
      tx_sof      <= 1'b0;
      tx_data     <= '0;
      tx_row      <= ROW_W'(1);
      tx_col      <= COL_W'(1);
      tx_underrun <= 1'b0;
    end else begin
      tx_valid <= strobe;
      tx_sof   <= frame_start;
      if (strobe) begin
        tx_data <= next_oct;
        tx_row  <= cur_row;
        tx_col  <= cur_col;
      end
      if (starved) tx_underrun <= 1'b1;
    end
  end

  // R4: start mark only on the first framing octet
  a_r4_sof_on_frame_word: assert property (@(posedge clk) disable iff (rst)
    tx_sof |-> (tx_valid && tx_data == OCT_W'(FRAME_WORD_A) &&
                tx_row == ROW_W'(1) && tx_col == COL_W'(1)));

  // R2: one output octet per strobe
  a_r2_valid_follows_strobe: assert property (@(posedge clk) disable iff (rst)
    strobe |=> tx_valid);

  a_r2_idle_no_valid: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> !tx_valid);

  // R1: no payload pull while the mode gate is closed
  a_r1_ready_gated: assert property (@(posedge clk) disable iff (rst)
    !active |-> !pl_ready);

  // R8: starved slot gives zero and raises the flag
  a_r8_zero_fill: assert property (@(posedge clk) disable iff (rst)
    starved |=> (tx_data == '0 && tx_underrun));

  // R8: flag is sticky
  a_r8_underrun_sticky: assert property (@(posedge clk) disable iff (rst)
    tx_underrun |=> tx_underrun);

endmodule

// File: tb/e3g832_framegen_tb_top.sv
module e3g832_framegen_tb_top;

  logic       clk = 1'b0;
  logic       rst;
  logic       cfg_ds3_sel, cfg_g832_sel;
  logic       oct_en;
  logic [7:0] pl_data;
  logic       pl_valid, pl_ready;
  logic       host_wr;
  logic [2:0] host_sel;
  logic [7:0] host_wdata;
  logic [7:0] tx_data;
  logic       tx_valid, tx_sof;
  logic [3:0] tx_row;
  logic [5:0] tx_col;
  logic       tx_underrun;

  always #2 clk = ~clk;

  e3g832_framegen dut_i (
    .clk(clk), .rst(rst), .cfg_ds3_sel(cfg_ds3_sel), .cfg_g832_sel(cfg_g832_sel),
    .oct_en(oct_en), .pl_data(pl_data), .pl_valid(pl_valid), .pl_ready(pl_ready),
    .host_wr(host_wr), .host_sel(host_sel), .host_wdata(host_wdata),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_sof(tx_sof),
    .tx_row(tx_row), .tx_col(tx_col), .tx_underrun(tx_underrun)
  );

  int n_checks = 0;
  int n_fail   = 0;

  int         m_row = 1;
  int         m_col = 1;
  logic [7:0] m_pend [5];
  logic [7:0] m_live [5];
  logic [7:0] src = 8'h00;
  bit         m_under = 0;
  bit         mode_on = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int row_len(input int r);
    return (r <= 6) ? 60 : 59;
  endfunction

  function automatic int slot_kind(input int r, input int c);
    if (r == 1 && c == 1) return 0;
    if (r == 1 && c == 2) return 1;
    if (r >= 2 && r <= 6 && c == 1) return 2;
    return 3;
  endfunction

  task automatic set_mode(input bit ds3, input bit g832);
    cfg_ds3_sel  = ds3;
    cfg_g832_sel = g832;
    mode_on      = !ds3 && g832;
  endtask

  task automatic step(input bit en, input bit vld, input string oh_tag);
    bit act_en;
    int kind;
    logic [7:0] ed;
    oct_en = en; pl_valid = vld; pl_data = src;
    #1;
    act_en = en && mode_on;
    kind   = slot_kind(m_row, m_col);
    chk(pl_ready === (act_en && kind == 3), mode_on ? "R7" : "R1", "pl_ready",
        int'(pl_ready), int'(act_en && kind == 3));
    @(posedge clk); #1;
    chk(tx_valid === act_en, mode_on ? "R2" : "R1", "tx_valid", int'(tx_valid), int'(act_en));
    if (act_en) begin
      ed = 8'h00;
      case (kind)
        0: begin ed = 8'hF6; m_live = m_pend; end
        1: ed = 8'h28;
        2: ed = m_live[m_row-2];
        default: begin
          if (vld) begin ed = src; src = src + 8'd1; end
          else begin ed = 8'h00; m_under = 1; end
        end
      endcase
      chk(tx_data === ed,
          kind < 2 ? "R4" : (kind == 2 ? oh_tag : (vld ? "R7" : "R8")),
          "tx_data", int'(tx_data), int'(ed));
      chk(tx_row === 4'(m_row) && tx_col === 6'(m_col), "R3", "row*100+col",
          int'(tx_row) * 100 + int'(tx_col), m_row * 100 + m_col);
      chk(tx_sof === (kind == 0), "R4", "tx_sof", int'(tx_sof), int'(kind == 0));
      if (m_col == row_len(m_row)) begin
        m_col = 1;
        m_row = (m_row == 9) ? 1 : m_row + 1;
      end else begin
        m_col++;
      end
    end else begin
      chk(tx_sof === 1'b0, mode_on ? "R2" : "R1", "tx_sof idle", int'(tx_sof), 0);
      if (!mode_on) begin m_row = 1; m_col = 1; end
    end
    chk(tx_underrun === m_under, "R8", "tx_underrun", int'(tx_underrun), int'(m_under));
    oct_en = 0; pl_valid = 0;
  endtask

  task automatic host_write(input int sel, input logic [7:0] val);
    host_wr = 1; host_sel = 3'(sel); host_wdata = val;
    @(posedge clk); #1;
    host_wr = 0;
    if (sel < 5) m_pend[sel] = val;
  endtask

  task automatic t_reset;
    rst = 1;
    repeat (3) @(posedge clk);
    #1;
    rst = 0;
    chk(tx_valid === 1'b0, "R9", "tx_valid after reset", int'(tx_valid), 0);
    chk(tx_sof === 1'b0, "R9", "tx_sof after reset", int'(tx_sof), 0);
    chk(tx_underrun === 1'b0, "R9", "tx_underrun after reset", int'(tx_underrun), 0);
    chk(pl_ready === 1'b0, "R9", "pl_ready after reset", int'(pl_ready), 0);
  endtask

  task automatic t_mode_gate;
    set_mode(1, 1);
    for (int i = 0; i < 4; i++) step(1, 1, "R1");
    set_mode(0, 0);
    for (int i = 0; i < 4; i++) step(1, 1, "R1");
    set_mode(1, 0);
    for (int i = 0; i < 2; i++) step(1, 1, "R1");
  endtask

  task automatic t_first_frame_r9;
    // R9: overhead registers start at zero; position starts at row 1 column 1
    set_mode(0, 1);
    for (int i = 0; i < 537; i++) step(1, 1, "R9");
  endtask

  task automatic t_full_frame;
    set_mode(1, 1);
    step(0, 0, "R1");
    host_write(0, 8'h11); host_write(1, 8'h22); host_write(2, 8'h33);
    host_write(3, 8'h44); host_write(4, 8'h55);
    host_write(5, 8'hEE); host_write(6, 8'hEE); host_write(7, 8'hEE);
    set_mode(0, 1);
    for (int i = 0; i < 537; i++) step(1, 1, "R5");
    step(1, 1, "R3");
    chk(m_row == 1 && m_col == 2, "R3", "model after wrap", m_row * 100 + m_col, 102);
  endtask

  task automatic t_oh_update;
    while (!(m_row == 2 && m_col == 10)) step(1, 1, "R6");
    host_write(0, 8'hA0); host_write(1, 8'hA1); host_write(2, 8'hA2);
    host_write(3, 8'hA3); host_write(4, 8'hA4);
    // R6: rest of this frame keeps old trail-trace..general values
    while (!(m_row == 1 && m_col == 1)) step(1, 1, "R6");
    for (int i = 0; i < 400; i++) step(1, 1, "R6");
    chk(m_live[1] == 8'hA1, "R6", "model live copy", int'(m_live[1]), 8'hA1);
  endtask

  task automatic t_gaps;
    for (int i = 0; i < 60; i++) step(i % 3 != 1, 1, "R2");
  endtask

  task automatic t_underrun;
    while (slot_kind(m_row, m_col) != 3) step(1, 1, "R7");
    for (int i = 0; i < 3; i++) step(1, 0, "R8");
    for (int i = 0; i < 30; i++) step(1, 1, "R8");
    chk(tx_underrun === 1'b1, "R8", "sticky flag", int'(tx_underrun), 1);
  endtask

  task automatic t_restart;
    while (!(m_row == 4 && m_col == 20)) step(1, 1, "R5");
    set_mode(0, 0);
    step(1, 1, "R1");
    set_mode(0, 1);
    step(1, 1, "R1");
    chk(tx_row === 4'd1 && tx_col === 6'd1 && tx_sof === 1'b1, "R1", "restart at frame start",
        int'(tx_row) * 100 + int'(tx_col), 101);
    for (int i = 0; i < 20; i++) step(1, 1, "R5");
  endtask

  bit finished = 0;

  initial begin
    rst = 1; host_wr = 0; host_sel = 0; host_wdata = 0;
    oct_en = 0; pl_valid = 0; pl_data = 0;
    for (int i = 0; i < 5; i++) begin m_pend[i] = 8'h00; m_live[i] = 8'h00; end
    set_mode(1, 1);
    t_reset();
    t_mode_gate();
    t_first_frame_r9();
    t_full_frame();
    t_oh_update();
    t_gaps();
    t_underrun();
    t_restart();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

endmodule